// File: doc/BRIEF.md
# Recycling Preset Decade Scaler

The block divides a periodic input signal, used directly as its clock, by an operator-chosen count between 2 and 9999. The count is entered as four BCD digits. An asynchronous start request arms the scaler. That request is first brought into the input clock domain, so the first counted cycle always begins on a clean edge, whatever its phase against the input. Once armed, the scaler counts input cycles down from the preset. It gives a one-clock pulse each time the count expires, and it reloads on that same edge, so the pulses come exactly N input cycles apart. It keeps recycling until a disable is applied.

A preset equal to the number of periods in a repeating pattern gives a pulse that is stationary against the pattern. A preset one higher or one lower makes the pulse step by one input cycle per revolution. An out-of-range preset raises an error flag, and the block then refuses to start.

Top module: `preset_decade_scaler`

## Requirements
- R1: While rst_n is low, pulse_o, running_o, error_o and count_o are all zero.
- R2: A preset is valid when each 4-bit digit of preset_i is 0..9 and the decimal value is at least 2. error_o is registered: after each rising edge it shows whether the preset sampled at that edge was invalid. A start request seen while the preset is invalid leaves the block idle.
- R3: start_i is synchronized by two flops. If the first rising edge at which start_i is high is edge k, and the block is idle, not disabled and has a valid preset, then running_o goes high after edge k+2. A new start needs start_i to go low and then high again.
- R4: On the starting edge, count_o (four BCD digits, least significant digit in bits 3:0) takes the preset. On each later edge while running it decrements by one in BCD, with every digit borrowing on the same edge.
- R5: While running, the edge at which count_o equals 1 reloads count_o with the preset captured at start and drives pulse_o high for exactly one cycle. Pulses therefore come every N cycles, and the first comes N edges after the starting edge.
- R6: A start request that arrives while running has no effect on count_o, on pulse_o or on their phase.
- R7: When disable_i is high at an edge, running_o and pulse_o are low after that edge. While idle, count_o is the preset_i sampled at the previous edge.
- R8: Changing preset_i while running does not change the reload value until the block is next started.
- R9: A start request whose synchronized rise meets an edge with disable_i high is discarded, and holding start_i high afterwards does not start the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Periodic input signal being counted |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Asynchronous start request, level with rising-edge meaning |
| disable_i | input | 1 | Synchronous stop; also blocks starting |
| preset_i | input | 16 | Four BCD digits of the division count |
| pulse_o | output | 1 | One-cycle pulse at each expiry of the count |
| running_o | output | 1 | High while the scaler is armed and cycling |
| error_o | output | 1 | Preset out of range or with a non-decimal digit |
| count_o | output | 16 | Remaining count in BCD, or the preset while idle |

## Verification
Every output is registered, so each result appears one edge after the inputs that cause it. The exception is the start path, which takes three edges from the first sampling of start_i to running_o. The bench reference model keeps a short history of start_i samples that reproduces this delay, steps once per rising edge, and is compared with all four outputs at the following falling edge. Start edges are driven at several fractions of the period, and the presets used include 2, 1000 and 9999, so that single-digit wraps, cascaded borrows and full-length revolutions are all covered.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
  localparam bcd_digit_t DIGIT_MAX = 4'd9;
endpackage

// File: rtl/start_sync.sv
module start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= 1'b0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/preset_check.sv
module preset_check
  import scaler_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] value_i,
  output logic                          valid_o
);
  logic [NUM_DIGITS-1:0] digit_ok;
  logic [NUM_DIGITS-1:0] digit_zero;
  logic                  upper_zero;
  logic                  low_small;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    bcd_digit_t dig;
    assign dig           = value_i[d*DIGIT_W +: DIGIT_W];
    assign digit_ok[d]   = (dig <= DIGIT_MAX);
    assign digit_zero[d] = (dig == '0);
  end

  if (NUM_DIGITS > 1) begin : g_upper
    assign upper_zero = &digit_zero[NUM_DIGITS-1:1];
  end else begin : g_single
    assign upper_zero = 1'b1;
  end

  always_comb begin
    low_small = (value_i[DIGIT_W-1:0] < bcd_digit_t'(2));
    valid_o   = (&digit_ok) & ~(upper_zero & low_small);
  end
endmodule

// File: rtl/bcd_down_counter.sv
module bcd_down_counter
  import scaler_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_en,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] load_val,
  input  logic                          dec_en,
  output logic [NUM_DIGITS*DIGIT_W-1:0] count_o,
  output logic                          at_one_o
);
  localparam int CW = NUM_DIGITS * DIGIT_W;

  logic [CW-1:0]         cnt_q, cnt_d;
  logic [NUM_DIGITS-1:0] zero_vec;
  logic [NUM_DIGITS-1:0] borrow_in;
  logic [CW-1:0]         dec_val;

  // parallel borrow: each digit looks at all lower digits at once
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    bcd_digit_t cur;
    assign cur         = cnt_q[d*DIGIT_W +: DIGIT_W];
    assign zero_vec[d] = (cur == '0);
    if (d == 0) begin : g_lsd
      assign borrow_in[d] = 1'b1;
    end else begin : g_hsd
      assign borrow_in[d] = &zero_vec[d-1:0];
    end
    always_comb begin
      if (!borrow_in[d])       dec_val[d*DIGIT_W +: DIGIT_W] = cur;
      else if (zero_vec[d])    dec_val[d*DIGIT_W +: DIGIT_W] = DIGIT_MAX;
      else                     dec_val[d*DIGIT_W +: DIGIT_W] = cur - 1'b1;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)     cnt_d = load_val;
    else if (dec_en) cnt_d = dec_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_en | dec_en) cnt_q <= cnt_d;
  end

  if (NUM_DIGITS > 1) begin : g_one_multi
    assign at_one_o = (&zero_vec[NUM_DIGITS-1:1]) &
                      (cnt_q[DIGIT_W-1:0] == bcd_digit_t'(1));
  end else begin : g_one_single
    assign at_one_o = (cnt_q[DIGIT_W-1:0] == bcd_digit_t'(1));
  end

  assign count_o = cnt_q;

  a_r4_lsd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load_en) |=>
      (($past(cnt_q[DIGIT_W-1:0]) == '0) ? (cnt_q[DIGIT_W-1:0] == DIGIT_MAX)
                                         : (cnt_q[DIGIT_W-1:0] == $past(cnt_q[DIGIT_W-1:0]) - 1'b1)));
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !load_en) |=> $stable(cnt_q));
endmodule

// File: rtl/preset_decade_scaler.sv
module preset_decade_scaler
  import scaler_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          disable_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] preset_i,
  output logic                          pulse_o,
  output logic                          running_o,
  output logic                          error_o,
  output logic [NUM_DIGITS*DIGIT_W-1:0] count_o
);
  localparam int CW = NUM_DIGITS * DIGIT_W;

  logic          trig;
  logic          preset_ok;
  logic          at_one;
  logic          running_q, running_d;
  logic          pulse_q, pulse_d;
  logic          error_q;
  logic [CW-1:0] held_q;
  logic          capture_en;
  logic          load_en, dec_en;
  logic [CW-1:0] load_val;

  start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (start_i),
    .rise_o  (trig)
  );

  preset_check #(.NUM_DIGITS(NUM_DIGITS)) u_check (
    .value_i (preset_i),
    .valid_o (preset_ok)
  );

  bcd_down_counter #(.NUM_DIGITS(NUM_DIGITS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_val (load_val),
    .dec_en   (dec_en),
    .count_o  (count_o),
    .at_one_o (at_one)
  );

  always_comb begin
    running_d  = running_q;
    pulse_d    = 1'b0;
    capture_en = 1'b0;
    if (disable_i) begin
      running_d = 1'b0;
    end else if (running_q) begin
      pulse_d = at_one;
    end else if (trig && preset_ok) begin
      running_d  = 1'b1;
      capture_en = 1'b1;
    end
    load_en  = ~running_q | disable_i | at_one;
    dec_en   = running_q & ~disable_i & ~at_one;
    load_val = (running_q & ~disable_i) ? held_q : preset_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      pulse_q   <= 1'b0;
      error_q   <= 1'b0;
    end else begin
      running_q <= running_d;
      pulse_q   <= pulse_d;
      error_q   <= ~preset_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held_q <= '0;
    else if (capture_en) held_q <= preset_i;
  end

  assign pulse_o   = pulse_q;
  assign running_o = running_q;
  assign error_o   = error_q;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (count_o == held_q));
  a_r7_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> (!running_q && !pulse_q));
  a_r2_start_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_q) |-> $past(preset_ok));
  a_r8_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && $past(running_q)) |-> $stable(held_q));
endmodule

// File: tb/preset_decade_scaler_tb.sv
`timescale 1ns/1ps
module preset_decade_scaler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        disable_i = 1'b0;
  logic [15:0] preset_i = 16'h0005;
  logic        pulse_o, running_o, error_o;
  logic [15:0] count_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string scene = "R1";

  always #2 clk = ~clk;

  preset_decade_scaler u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .disable_i(disable_i),
    .preset_i(preset_i), .pulse_o(pulse_o), .running_o(running_o),
    .error_o(error_o), .count_o(count_o)
  );

  function automatic int bcd_value(logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  function automatic logic [15:0] to_bcd(int n);
    return {4'(n/1000), 4'((n/100)%10), 4'((n/10)%10), 4'(n%10)};
  endfunction

  function automatic bit is_valid(logic [15:0] v);
    if (v[15:12] > 9 || v[11:8] > 9 || v[7:4] > 9 || v[3:0] > 9) return 1'b0;
    return bcd_value(v) >= 2;
  endfunction

  // behavioural reference
  bit          m_run, m_pulse, m_err;
  int          m_cnt, m_held;
  logic [15:0] m_idle_cnt;
  bit          h1, h2, h3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pulse = 0; m_err = 0; m_cnt = 0; m_held = 0;
      m_idle_cnt = '0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit trig;
      trig = h2 && !h3;
      h3 = h2; h2 = h1; h1 = start_i;
      m_err = !is_valid(preset_i);
      m_pulse = 0;
      if (disable_i) begin
        m_run = 0; m_idle_cnt = preset_i;
      end else if (m_run) begin
        if (m_cnt == 1) begin m_cnt = m_held; m_pulse = 1; end
        else m_cnt = m_cnt - 1;
      end else if (trig && is_valid(preset_i)) begin
        m_run = 1; m_held = bcd_value(preset_i); m_cnt = m_held;
      end else begin
        m_idle_cnt = preset_i;
      end
    end
  end

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s (scene %s) t=%0t got=%0h exp=%0h", tag, scene, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 pulse", {15'b0, pulse_o}, {15'b0, m_pulse});
      check("R3 running", {15'b0, running_o}, {15'b0, m_run});
      check("R2 error", {15'b0, error_o}, {15'b0, m_err});
      check("R4 count", count_o, m_run ? to_bcd(m_cnt) : m_idle_cnt);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired got=%0d exp<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_pulse(int hold, realtime ofs);
    @(posedge clk); #(ofs) start_i = 1'b1;
    repeat (hold) @(posedge clk);
    #(ofs) start_i = 1'b0;
  endtask

  initial begin
    scene = "R1";
    wait_cycles(3);
    check("R1 pulse", {15'b0, pulse_o}, 16'h0);
    check("R1 running", {15'b0, running_o}, 16'h0);
    check("R1 error", {15'b0, error_o}, 16'h0);
    check("R1 count", count_o, 16'h0);
    rst_n = 1'b1;
    wait_cycles(2);

    scene = "R5"; preset_i = to_bcd(5);
    start_pulse(3, 1.0); wait_cycles(30);

    scene = "R6"; start_pulse(2, 3.0); wait_cycles(20);

    scene = "R8"; @(negedge clk) preset_i = to_bcd(7); wait_cycles(20);

    scene = "R7"; @(negedge clk) disable_i = 1'b1;
    @(negedge clk) disable_i = 1'b0; wait_cycles(5);
    @(negedge clk) preset_i = to_bcd(3); wait_cycles(3);

    scene = "R5"; preset_i = to_bcd(2);
    start_pulse(1, 0.5); wait_cycles(12);
    @(negedge clk) disable_i = 1'b1; @(negedge clk) disable_i = 1'b0;

    scene = "R4"; preset_i = to_bcd(1000);
    start_pulse(2, 2.5); wait_cycles(2100);
    @(negedge clk) disable_i = 1'b1; @(negedge clk) disable_i = 1'b0;

    scene = "R4"; preset_i = to_bcd(9999);
    start_pulse(2, 1.5); wait_cycles(20010);
    @(negedge clk) disable_i = 1'b1; @(negedge clk) disable_i = 1'b0;

    scene = "R2"; preset_i = to_bcd(1);
    start_pulse(2, 1.0); wait_cycles(8);
    @(negedge clk) preset_i = 16'h0000; start_pulse(2, 2.0); wait_cycles(8);
    @(negedge clk) preset_i = 16'h00A5; start_pulse(2, 3.0); wait_cycles(8);
    @(negedge clk) preset_i = 16'h1F00; wait_cycles(4);

    scene = "R9"; @(negedge clk) begin preset_i = to_bcd(3); disable_i = 1'b1; end
    start_i = 1'b1; wait_cycles(6);
    @(negedge clk) disable_i = 1'b0; wait_cycles(10);
    @(negedge clk) start_i = 1'b0; wait_cycles(4);

    scene = "R3"; start_pulse(1, 3.5); wait_cycles(15);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule